// File: doc/BRIEF.md
# DMA Start Vector Channel Arbiter

This block decides, for every incoming interrupt request, whether a DMA channel services it or the CPU does. Each DMA channel owns a start vector register and a transfer counter. A request whose vector code equals the value armed in a channel's register is claimed by that channel and becomes a DMA start. A request that no channel claims is passed on as an ordinary CPU interrupt request. The data movement itself is done elsewhere. This block only reports the chosen channel.

Every claimed request uses up one transfer from the serving channel's counter. When the counter goes from one to zero, the channel raises its transfer-end interrupt and disarms itself by clearing its vector register. Several channels may hold the same vector. In that case the lowest-numbered eligible channel wins. Once it has disarmed, later requests with that vector fall through to the next channel that holds it, so channels chain without software help. Software can re-arm a channel from its end handler. A vector write in the same cycle as the disarm takes precedence over the clear.

Top module: `dma_vec_arb`

## Requirements
- R1: After a synchronous reset, all vector registers and counters are zero, and `dma_hit`, `cpu_irq`, `end_irq` and `cpu_vec` are all zero.
- R2: When `wr_en` is high, `wr_vec` is stored in the vector register of channel `wr_ch`. A stored value of 0 disarms the channel so that it never matches.
- R3: A valid request whose `req_vec` equals the nonzero vector of a channel with a nonzero counter gives, on the next cycle, `dma_hit`=1 with `dma_ch` set to that channel and `cpu_irq`=0.
- R4: A valid request that no eligible channel matches gives, on the next cycle, `cpu_irq`=1 with `cpu_vec` equal to the request vector, and `dma_hit`=0.
- R5: When several eligible channels match, the lowest-numbered one is selected.
- R6: Each DMA grant decrements the serving channel's counter by exactly one.
- R7: A grant that takes a counter from 1 to 0 raises bit `ch` of `end_irq` for one cycle, in the same cycle as `dma_hit`, and clears that channel's vector register.
- R8: After the winning channel disarms, later requests with the same vector go to the next higher-numbered channel that holds that vector.
- R9: A vector write to a channel in the cycle that its counter reaches zero takes effect instead of the clear.
- R10: `cnt_ld_en[i]` loads `cnt_ld_val` into channel i's counter. A load in the same cycle as a grant to that channel wins over the decrement, and no end interrupt is raised.
- R11: While `req_valid` is low, `dma_hit` and `cpu_irq` stay low on the next cycle.
- R12: A channel whose counter is zero does not match, even when its vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Vector register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_vec | input | VW | Vector value to store (0 disarms) |
| cnt_ld_en | input | NCH | Per-channel counter load strobe |
| cnt_ld_val | input | CW | Counter load value |
| req_valid | input | 1 | Interrupt request present |
| req_vec | input | VW | Vector code of the request |
| dma_hit | output | 1 | Registered: request claimed by a DMA channel |
| dma_ch | output | CHW | Registered: serving channel |
| cpu_irq | output | 1 | Registered: request forwarded to the CPU |
| cpu_vec | output | VW | Registered: vector of the forwarded request |
| end_irq | output | NCH | Registered: transfer-end pulses, one bit per channel |

## Verification
Some properties are checked by assertions on every cycle:
- DMA and CPU outcomes never occur together.
- Either outcome appears only after a valid request.
- A forwarded vector equals the vector that was requested.
- An end pulse lasts one cycle and appears only together with a grant to the same channel.

Other behaviour depends on armed state built up over many cycles, so only the bench scenarios can show it:
- which channel wins among duplicates;
- the exact number of grants before disarm;
- chaining to the next channel;
- a re-arm write winning over the clear;
- a load winning over the decrement.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_DMA  = 2'd1,
    ARB_CPU  = 2'd2
  } arb_kind_e;
endpackage

// File: rtl/dma_vec_bank.sv
module dma_vec_bank #(
  parameter int NCH = 4,
  parameter int VW  = 6,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CHW-1:0]          wr_ch,
  input  logic [VW-1:0]           wr_vec,
  input  logic [NCH-1:0]          ld_en,
  input  logic [CW-1:0]           ld_val,
  input  logic                    grant_en,
  input  logic [CHW-1:0]          grant_ch,
  output logic [NCH-1:0][VW-1:0]  vec_q,
  output logic [NCH-1:0]          live,
  output logic [NCH-1:0]          end_now
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CW-1:0] cnt_q;
    logic          served;

    assign served       = grant_en && (grant_ch == CHW'(ch));
    assign end_now[ch]  = served && !ld_en[ch] && (cnt_q == CW'(1));
    assign live[ch]     = (vec_q[ch] != '0) && (cnt_q != '0);

    always_ff @(posedge clk) begin
      if (rst)
        cnt_q <= '0;
      else if (ld_en[ch])
        cnt_q <= ld_val;
      else if (served && cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
      if (rst)
        vec_q[ch] <= '0;
      else if (wr_en && wr_ch == CHW'(ch))
        vec_q[ch] <= wr_vec;
      else if (end_now[ch])
        vec_q[ch] <= '0;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/dma_vec_arb.sv
module dma_vec_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int VW  = 6,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [VW-1:0]  wr_vec,
  input  logic [NCH-1:0] cnt_ld_en,
  input  logic [CW-1:0]  cnt_ld_val,
  input  logic           req_valid,
  input  logic [VW-1:0]  req_vec,
  output logic           dma_hit,
  output logic [CHW-1:0] dma_ch,
  output logic           cpu_irq,
  output logic [VW-1:0]  cpu_vec,
  output logic [NCH-1:0] end_irq
);
  logic [NCH-1:0][VW-1:0] vec_q;
  logic [NCH-1:0]         live;
  logic [NCH-1:0]         end_now;
  logic [NCH-1:0]         match;
  logic                   any_match;
  logic [CHW-1:0]         win_ch;
  arb_kind_e              kind_d;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign match[i] = req_valid && live[i] && (vec_q[i] == req_vec);
  end

  dma_prio_pick #(.N(NCH)) u_pick (
    .req (match),
    .any (any_match),
    .idx (win_ch)
  );

  dma_vec_bank #(.NCH(NCH), .VW(VW), .CW(CW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_vec   (wr_vec),
    .ld_en    (cnt_ld_en),
    .ld_val   (cnt_ld_val),
    .grant_en (any_match),
    .grant_ch (win_ch),
    .vec_q    (vec_q),
    .live     (live),
    .end_now  (end_now)
  );

  always_comb begin
    if (!req_valid)     kind_d = ARB_IDLE;
    else if (any_match) kind_d = ARB_DMA;
    else                kind_d = ARB_CPU;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_hit <= 1'b0;
      dma_ch  <= '0;
      cpu_irq <= 1'b0;
      cpu_vec <= '0;
      end_irq <= '0;
    end else begin
      dma_hit <= (kind_d == ARB_DMA);
      dma_ch  <= (kind_d == ARB_DMA) ? win_ch : '0;
      cpu_irq <= (kind_d == ARB_CPU);
      cpu_vec <= (kind_d == ARB_CPU) ? req_vec : '0;
      end_irq <= end_now;
    end
  end
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH = 4,
  parameter int VW  = 6,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [VW-1:0]  req_vec,
  input logic           dma_hit,
  input logic [CHW-1:0] dma_ch,
  input logic           cpu_irq,
  input logic [VW-1:0]  cpu_vec,
  input logic [NCH-1:0] end_irq
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(dma_hit && cpu_irq));

  assert_dma_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    dma_hit |-> $past(req_valid));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (dma_hit || cpu_irq) |-> $past(req_valid));

  assert_cpu_vec_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (cpu_vec == $past(req_vec)));

  assert_end_with_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (end_irq != '0) |-> (dma_hit && end_irq == (NCH'(1) << dma_ch)));

  for (genvar i = 0; i < NCH; i++) begin : g_pulse
    assert_end_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      end_irq[i] |=> !end_irq[i]);
  end
endmodule

bind dma_vec_arb dma_arb_chk #(.NCH(NCH), .VW(VW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vec   (req_vec),
  .dma_hit   (dma_hit),
  .dma_ch    (dma_ch),
  .cpu_irq   (cpu_irq),
  .cpu_vec   (cpu_vec),
  .end_irq   (end_irq)
);

// File: tb/sim_dma_vec_arb.sv
`timescale 1ns/1ps
module sim_dma_vec_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [5:0]  wr_vec = '0;
  logic [3:0]  cnt_ld_en = '0;
  logic [15:0] cnt_ld_val = '0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_vec = '0;
  logic        dma_hit;
  logic [1:0]  dma_ch;
  logic        cpu_irq;
  logic [5:0]  cpu_vec;
  logic [3:0]  end_irq;

  always #2 clk = ~clk;

  dma_vec_arb u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_vec(wr_vec),
    .cnt_ld_en(cnt_ld_en), .cnt_ld_val(cnt_ld_val), .req_valid(req_valid),
    .req_vec(req_vec), .dma_hit(dma_hit), .dma_ch(dma_ch), .cpu_irq(cpu_irq),
    .cpu_vec(cpu_vec), .end_irq(end_irq)
  );

  typedef struct {
    logic       hit;
    logic [1:0] ch;
    logic       irq;
    logic [5:0] vec;
    logic [3:0] endv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [5:0]  mv [4];
  logic [15:0] mc [4];

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input int wch, input int wv, input logic [3:0] ld,
                      input int lv, input bit rv, input int rvec, input string tag);
    exp_t e;
    int sel;
    @(negedge clk);
    wr_en = we; wr_ch = 2'(wch); wr_vec = 6'(wv);
    cnt_ld_en = ld; cnt_ld_val = 16'(lv);
    req_valid = rv; req_vec = 6'(rvec);
    sel = -1;
    for (int i = 0; i < 4; i++)
      if (sel < 0 && rv && mv[i] != 0 && mc[i] != 0 && mv[i] == 6'(rvec)) sel = i;
    e.hit = (sel >= 0);
    e.ch = (sel >= 0) ? 2'(sel) : 2'd0;
    e.irq = rv && (sel < 0);
    e.vec = e.irq ? 6'(rvec) : 6'd0;
    e.endv = '0;
    if (sel >= 0 && !ld[sel] && mc[sel] == 1) e.endv[sel] = 1'b1;
    e.tag = tag;
    for (int i = 0; i < 4; i++) begin
      if (ld[i]) mc[i] = 16'(lv);
      else if (i == sel && mc[i] != 0) mc[i] = mc[i] - 1;
      if (e.endv[i]) mv[i] = '0;
      if (we && wch == i) mv[i] = 6'(wv);
    end
    q.push_back(e);
  endtask

  task automatic req(input int v, input string tag);
    step(0, 0, 0, 4'b0, 0, 1, v, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "dma_hit", dma_hit, e.hit);
        check(e.tag, "dma_ch", dma_ch, e.ch);
        check(e.tag, "cpu_irq", cpu_irq, e.irq);
        check(e.tag, "cpu_vec", cpu_vec, e.vec);
        check(e.tag, "end_irq", end_irq, e.endv);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = '0; mc[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    check("R1", "dma_hit", dma_hit, 0);
    check("R1", "cpu_irq", cpu_irq, 0);
    check("R1", "end_irq", end_irq, 0);
    check("R1", "cpu_vec", cpu_vec, 0);
    // R1/R4: all registers zero, so any request goes to the CPU
    req(5, "R1");
    req(0, "R2");
    // R2/R3/R6/R7: arm ch1 with two transfers
    step(1, 1, 5, 4'b0010, 2, 0, 0, "R2");
    req(5, "R3");
    req(5, "R6");
    req(5, "R7");
    // R5/R8: duplicates on ch0 and ch2
    step(1, 0, 9, 4'b0101, 2, 0, 0, "R5");
    step(1, 2, 9, 4'b0000, 0, 0, 0, "R5");
    step(0, 0, 0, 4'b0100, 3, 0, 0, "R5");
    req(9, "R5");
    req(9, "R5");
    req(9, "R8");
    req(9, "R8");
    req(9, "R8");
    req(9, "R4");
    // R2: writing 0 disarms
    step(1, 2, 9, 4'b0100, 4, 0, 0, "R2");
    step(1, 2, 0, 4'b0000, 0, 0, 0, "R2");
    req(9, "R2");
    // R9: re-arm write in the end cycle wins
    step(1, 3, 12, 4'b1000, 1, 0, 0, "R9");
    step(1, 3, 12, 4'b0000, 0, 1, 12, "R9");
    req(12, "R12");
    step(0, 0, 0, 4'b1000, 1, 0, 0, "R9");
    req(12, "R9");
    // R10: a load wins over the decrement
    step(1, 0, 20, 4'b0001, 1, 0, 0, "R10");
    step(0, 0, 0, 4'b0001, 3, 1, 20, "R10");
    req(20, "R10");
    req(20, "R10");
    req(20, "R10");
    req(20, "R10");
    // R11: no request means no outcome
    step(1, 1, 30, 4'b0010, 5, 0, 0, "R11");
    step(0, 0, 0, 4'b0000, 0, 0, 30, "R11");
    req(30, "R3");
    // R12: zero counter is not eligible
    step(1, 3, 33, 4'b0000, 0, 0, 0, "R12");
    req(33, "R12");
    step(0, 0, 0, 4'b0000, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule